// File: doc/BRIEF.md
# Parallel Register Port with Byte Sequencing

This block is the host-facing register port of a converter peripheral that sits on a parallel bus. A host writes 16-bit words, either all at once on the full bus or as two bytes on the lower eight lines. The `word_mode` input chooses between the two. Each assembled word carries a 2-bit destination code in its top two bits and a 14-bit payload below it. The payload goes to the test register, to one calibration slot, or to the control register. Destination code 00 discards the write.

Reads do not carry an address. Two bits of the control register act as a sticky read selector. They pick the conversion result, the test register, the selected calibration slot or the status word, and that choice holds for every read until a later control write changes it. The control register has no read path. The conversion result and the status word come in on input ports and can only be read. In byte mode a read returns the low half on the first strobe and the high half on the second. The high half is captured when the low half is read, so both halves belong to the same value.

Top module: `regport_top`

## Requirements
- R1: With `word_mode`=1, a `wr_en` strobe takes `din[15:14]` as destination and `din[13:0]` as payload. The addressed register holds the new payload from the clock edge that samples the strobe.
- R2: With `word_mode`=0, a write takes two strobes. The first carries bits 7..0 on `din[7:0]` and the second carries bits 15..8 on `din[7:0]`. No register changes until the second strobe.
- R3: Destination 01 writes the test register and 11 writes the control register. Destination 10 writes the calibration slot indexed by control bits [1:0].
- R4: A write with destination 00 leaves the test register, every calibration slot and the control register unchanged.
- R5: Control bits [7:6] select the read source: 00 conversion result, 01 test, 10 the calibration slot indexed by control bits [1:0], 11 status. The 14-bit sources read as {2'b00, value}.
- R6: After reset the registers are zero, `dout` is zero, both byte phases expect a low byte, and a read returns the conversion result.
- R7: The read selection stays unchanged through reads and through writes to any destination other than 11.
- R8: A read of the conversion result returns it right-aligned, with the bits above `ADC_W` at zero.
- R9: With `word_mode`=0, the first read strobe returns bits 7..0 and the second returns bits 15..8, both on `dout[7:0]` with `dout[15:8]`=0. The high byte is the one captured at the low-byte read.
- R10: `dout` updates at the edge that samples `rd_en` and holds its value in every other cycle.
- R11: A change of `word_mode` returns both the write and the read byte phase to "low byte expected", and any half-built word is dropped.
- R12: When `rd_en` and `wr_en` are sampled at the same edge, the read returns data chosen by, and taken from, the register state before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_mode | input | 1 | 1: 16-bit transfers, 0: byte transfers on lines 7..0 |
| wr_en | input | 1 | Write strobe, one cycle per transfer |
| rd_en | input | 1 | Read strobe, one cycle per transfer |
| din | input | 16 | Write data |
| adc_result | input | ADC_W | Conversion result (read-only source) |
| status_word | input | 14 | Status word (read-only source) |
| dout | output | 16 | Read data, registered |

## Verification
A read and a write can be sampled at the same edge. The hard case is a control write that moves the read selector while a read is in flight. The bench drives `rd_en` and `wr_en` in one cycle with a control write that switches the selector from the test register to status. It expects the test register's value from that read and the status word from the next read. A second overlap occurs in byte mode: a calibration write lands between the two halves of a read, and the high half must still come from the value captured at the low-half read.

// File: rtl/regport_pkg.sv
package regport_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int DEST_W = 2;
  localparam int PAY_W  = WORD_W - DEST_W;
  localparam int RSEL_LSB = 6;
  localparam int CSEL_LSB = 0;

  typedef enum logic [DEST_W-1:0] {
    DEST_NONE = 2'b00,
    DEST_TEST = 2'b01,
    DEST_CAL  = 2'b10,
    DEST_CTRL = 2'b11
  } dest_e;

  typedef enum logic [1:0] {
    SRC_ADC  = 2'b00,
    SRC_TEST = 2'b01,
    SRC_CAL  = 2'b10,
    SRC_STAT = 2'b11
  } rsrc_e;

  function automatic logic [WORD_W-1:0] join_halves(input logic [BYTE_W-1:0] hi,
                                                    input logic [BYTE_W-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic dest_e dest_of(input logic [WORD_W-1:0] w);
    return dest_e'(w[WORD_W-1 -: DEST_W]);
  endfunction

  function automatic logic [PAY_W-1:0] payload_of(input logic [WORD_W-1:0] w);
    return w[PAY_W-1:0];
  endfunction

  function automatic logic [WORD_W-1:0] widen14(input logic [PAY_W-1:0] p);
    return {{DEST_W{1'b0}}, p};
  endfunction
endpackage

// File: rtl/regport_wr_asm.sv
module regport_wr_asm
  import regport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              word_mode,
  input  logic              mode_chg,
  input  logic [WORD_W-1:0] din,
  output logic              commit,
  output logic [WORD_W-1:0] word_out,
  output logic              phase_hi
);
  logic              phase_q;
  logic [BYTE_W-1:0] low_q;
  logic              phase_eff;

  assign phase_eff = phase_q & ~mode_chg;
  assign commit    = wr_en & (word_mode | phase_eff);
  assign word_out  = word_mode ? din : join_halves(din[BYTE_W-1:0], low_q);
  assign phase_hi  = phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      low_q   <= '0;
    end else if (wr_en && !word_mode) begin
      if (!phase_eff) begin
        low_q   <= din[BYTE_W-1:0];
        phase_q <= 1'b1;
      end else begin
        phase_q <= 1'b0;
      end
    end else if (mode_chg || word_mode) begin
      phase_q <= 1'b0;
    end
  end
endmodule

// File: rtl/regport_bank.sv
module regport_bank
  import regport_pkg::*;
#(
  parameter int CSEL_W = 2,
  localparam int SLOTS = 1 << CSEL_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   commit,
  input  logic [WORD_W-1:0]      word_in,
  output logic [PAY_W-1:0]       test_q,
  output logic [PAY_W-1:0]       ctrl_q,
  output logic [SLOTS*PAY_W-1:0] cal_flat,
  output logic [PAY_W-1:0]       cal_rd,
  output logic [1:0]             rd_sel,
  output logic [CSEL_W-1:0]      cal_sel,
  output logic                   wr_null
);
  dest_e            dest;
  logic [PAY_W-1:0] pay;
  logic             wr_test, wr_cal, wr_ctrl;

  assign dest    = dest_of(word_in);
  assign pay     = payload_of(word_in);
  assign wr_test = commit && (dest == DEST_TEST);
  assign wr_cal  = commit && (dest == DEST_CAL);
  assign wr_ctrl = commit && (dest == DEST_CTRL);
  assign wr_null = commit && (dest == DEST_NONE);

  assign rd_sel  = ctrl_q[RSEL_LSB +: 2];
  assign cal_sel = ctrl_q[CSEL_LSB +: CSEL_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      test_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_test) test_q <= pay;
      if (wr_ctrl) ctrl_q <= pay;
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [PAY_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                             slot_q <= '0;
      else if (wr_cal && cal_sel == CSEL_W'(s)) slot_q <= pay;
    end
    assign cal_flat[s*PAY_W +: PAY_W] = slot_q;
  end

  assign cal_rd = cal_flat[cal_sel*PAY_W +: PAY_W];
endmodule

// File: rtl/regport_rd_seq.sv
module regport_rd_seq
  import regport_pkg::*;
#(
  parameter int ADC_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              word_mode,
  input  logic              mode_chg,
  input  logic [1:0]        rd_sel,
  input  logic [ADC_W-1:0]  adc_result,
  input  logic [PAY_W-1:0]  test_q,
  input  logic [PAY_W-1:0]  cal_rd,
  input  logic [PAY_W-1:0]  status_word,
  output logic [WORD_W-1:0] dout,
  output logic              phase_hi
);
  logic [WORD_W-1:0] rd_word;
  logic [BYTE_W-1:0] hold_q;
  logic              phase_q;
  logic              phase_eff;

  always_comb begin
    case (rsrc_e'(rd_sel))
      SRC_ADC:  rd_word = {{(WORD_W-ADC_W){1'b0}}, adc_result};
      SRC_TEST: rd_word = widen14(test_q);
      SRC_CAL:  rd_word = widen14(cal_rd);
      default:  rd_word = widen14(status_word);
    endcase
  end

  assign phase_eff = phase_q & ~mode_chg;
  assign phase_hi  = phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout    <= '0;
      hold_q  <= '0;
      phase_q <= 1'b0;
    end else if (rd_en) begin
      if (word_mode) begin
        dout    <= rd_word;
        phase_q <= 1'b0;
      end else if (!phase_eff) begin
        dout    <= {{BYTE_W{1'b0}}, rd_word[BYTE_W-1:0]};
        hold_q  <= rd_word[WORD_W-1:BYTE_W];
        phase_q <= 1'b1;
      end else begin
        dout    <= {{BYTE_W{1'b0}}, hold_q};
        phase_q <= 1'b0;
      end
    end else if (mode_chg || word_mode) begin
      phase_q <= 1'b0;
    end
  end
endmodule

// File: rtl/regport_top.sv
module regport_top
  import regport_pkg::*;
#(
  parameter int ADC_W  = 12,
  parameter int CSEL_W = 2,
  localparam int SLOTS = 1 << CSEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_mode,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [15:0]       din,
  input  logic [ADC_W-1:0]  adc_result,
  input  logic [13:0]       status_word,
  output logic [15:0]       dout
);
  logic                   mode_q;
  logic                   mode_chg;
  logic                   commit;
  logic [WORD_W-1:0]      word_asm;
  logic [1:0]             commit_dest;
  logic                   wr_phase, rd_phase, wr_null;
  logic [PAY_W-1:0]       test_q, ctrl_q, cal_rd;
  logic [SLOTS*PAY_W-1:0] cal_flat;
  logic [1:0]             rd_sel;
  logic [CSEL_W-1:0]      cal_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= 1'b1;
    else        mode_q <= word_mode;
  end
  assign mode_chg    = word_mode ^ mode_q;
  assign commit_dest = word_asm[WORD_W-1 -: DEST_W];

  regport_wr_asm u_wr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .word_mode(word_mode),
    .mode_chg(mode_chg), .din(din), .commit(commit), .word_out(word_asm),
    .phase_hi(wr_phase)
  );

  regport_bank #(.CSEL_W(CSEL_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .commit(commit), .word_in(word_asm),
    .test_q(test_q), .ctrl_q(ctrl_q), .cal_flat(cal_flat), .cal_rd(cal_rd),
    .rd_sel(rd_sel), .cal_sel(cal_sel), .wr_null(wr_null)
  );

  regport_rd_seq #(.ADC_W(ADC_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .word_mode(word_mode),
    .mode_chg(mode_chg), .rd_sel(rd_sel), .adc_result(adc_result),
    .test_q(test_q), .cal_rd(cal_rd), .status_word(status_word),
    .dout(dout), .phase_hi(rd_phase)
  );
endmodule

// File: rtl/regport_chk.sv
module regport_chk #(
  parameter int ADC_W = 12,
  parameter int CSEL_W = 2,
  parameter int SLOTS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic                 rd_en,
  input logic                 word_mode,
  input logic                 mode_chg,
  input logic                 commit,
  input logic [1:0]           commit_dest,
  input logic                 wr_phase,
  input logic                 wr_null,
  input logic [13:0]          test_q,
  input logic [13:0]          ctrl_q,
  input logic [SLOTS*14-1:0]  cal_flat,
  input logic [1:0]           rd_sel,
  input logic [CSEL_W-1:0]    cal_sel,
  input logic [15:0]          dout
);
  assert_word_commit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && word_mode |-> commit);

  assert_low_byte_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !word_mode && !wr_phase |-> !commit);

  assert_null_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_null |=> $stable(test_q) && $stable(ctrl_q) && $stable(cal_flat));

  assert_sticky_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && commit_dest == 2'b11) |=> $stable(rd_sel) && $stable(cal_sel));

  assert_adc_zeros_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && word_mode && rd_sel == 2'b00 |=> (dout >> ADC_W) == 16'h0000);

  assert_byte_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !word_mode |=> dout[15:8] == 8'h00);

  assert_dout_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(dout));

  assert_phase_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg && !wr_en |=> !wr_phase);
endmodule

bind regport_top regport_chk #(.ADC_W(ADC_W), .CSEL_W(CSEL_W), .SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .word_mode(word_mode),
  .mode_chg(mode_chg), .commit(commit), .commit_dest(commit_dest),
  .wr_phase(wr_phase), .wr_null(wr_null), .test_q(test_q), .ctrl_q(ctrl_q),
  .cal_flat(cal_flat), .rd_sel(rd_sel), .cal_sel(cal_sel), .dout(dout)
);

// File: tb/sim_regport_top.sv
module sim_regport_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_mode = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] din = '0;
  logic [11:0] adc_result = 12'hA5C;
  logic [13:0] status_word = 14'h0F0F;
  logic [15:0] dout;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  regport_top u0 (
    .clk(clk), .rst_n(rst_n), .word_mode(word_mode), .wr_en(wr_en),
    .rd_en(rd_en), .din(din), .adc_result(adc_result),
    .status_word(status_word), .dout(dout)
  );

  // reference model
  logic [13:0] m_test = '0;
  logic [13:0] m_ctrl = '0;
  logic [13:0] m_cal [4] = '{default: '0};
  logic [7:0]  m_hold = '0;

  logic [15:0] exp_q [$];
  string       tag_q [$];
  bit          rd_seen = 0;

  function automatic logic [15:0] model_read();
    case (m_ctrl[7:6])
      2'd0: return {4'h0, adc_result};
      2'd1: return {2'b00, m_test};
      2'd2: return {2'b00, m_cal[m_ctrl[1:0]]};
      default: return {2'b00, status_word};
    endcase
  endfunction

  function automatic void model_write(input logic [15:0] w);
    case (w[15:14])
      2'b01: m_test = w[13:0];
      2'b10: m_cal[m_ctrl[1:0]] = w[13:0];
      2'b11: m_ctrl = w[13:0];
      default: ;
    endcase
  endfunction

  function automatic logic [15:0] ctrl_word(input logic [1:0] rs, input logic [1:0] cs);
    return {2'b11, 6'b0, rs, 4'b0, cs};
  endfunction

  task automatic check(input logic [15:0] got, input logic [15:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // monitor: compares each read result one negedge after it is sampled
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        checks++; bad++;
        $display("FAIL R10: unexpected read result %h expected none", dout);
      end else begin
        check(dout, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic wr_word(input logic [15:0] w);
    @(negedge clk); din = w; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    model_write(w);
  endtask

  task automatic wr_byte(input logic [7:0] b);
    @(negedge clk); din = {8'h00, b}; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wr_bytes(input logic [15:0] w);
    wr_byte(w[7:0]);
    wr_byte(w[15:8]);
    model_write(w);
  endtask

  task automatic rd_pulse(input logic [15:0] exp, input string tag);
    @(negedge clk); exp_q.push_back(exp); tag_q.push_back(tag); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic rd_word(input string tag);
    rd_pulse(model_read(), tag);
  endtask

  task automatic rd_low(input string tag);
    logic [15:0] v;
    v = model_read();
    m_hold = v[15:8];
    rd_pulse({8'h00, v[7:0]}, tag);
  endtask

  task automatic rd_high(input string tag);
    rd_pulse({8'h00, m_hold}, tag);
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk); word_mode = m;
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(dout, 16'h0000, "R6 dout after reset");
    rd_word("R6 R8 default source is conversion result");

    wr_word(ctrl_word(2'd1, 2'd0));
    rd_word("R5 test register after reset");
    wr_word({2'b01, 14'h1234});
    rd_word("R1 R3 word write to test");
    wr_word({2'b00, 14'h3FFF});
    rd_word("R4 R7 null write keeps test and selection");

    wr_word(ctrl_word(2'd2, 2'd2));
    wr_word({2'b10, 14'h2ABC});
    rd_word("R3 R5 calibration slot 2");
    wr_word(ctrl_word(2'd2, 2'd0));
    rd_word("R3 calibration slot 0 untouched");
    wr_word({2'b00, 14'h0155});
    rd_word("R4 null write keeps control and slot 0");
    wr_word(ctrl_word(2'd2, 2'd2));
    rd_word("R4 slot 2 intact after null write");

    wr_word(ctrl_word(2'd3, 2'd0));
    rd_word("R5 status source");
    rd_word("R7 selection holds over reads");
    adc_result = 12'h3C1;
    wr_word(ctrl_word(2'd0, 2'd0));
    rd_word("R8 conversion result right aligned");

    // byte mode
    set_mode(1'b0);
    wr_bytes(ctrl_word(2'd1, 2'd0));
    rd_low("R9 low byte first");
    rd_high("R9 high byte second");
    wr_byte(8'h57);
    rd_low("R2 low byte alone does not commit");
    rd_high("R2 low byte alone does not commit, high half");
    wr_byte(8'h53);
    model_write(16'h5357);
    rd_low("R2 byte pair committed low");
    rd_high("R2 byte pair committed high");

    wr_bytes(ctrl_word(2'd2, 2'd2));
    rd_low("R9 calibration low byte");
    wr_bytes({2'b10, 14'h0F11});
    rd_high("R9 high byte captured at low read");
    rd_low("R9 new calibration low");
    rd_high("R9 new calibration high");

    // mode change drops a half-built write and rewinds read phase
    wr_byte(8'hEE);
    set_mode(1'b1);
    set_mode(1'b0);
    wr_bytes(ctrl_word(2'd1, 2'd0));
    wr_bytes({2'b01, 14'h0246});
    rd_low("R11 write phase rewound, low");
    rd_high("R11 write phase rewound, high");
    rd_low("R11 read before mode change");
    set_mode(1'b1);
    set_mode(1'b0);
    rd_low("R11 read phase rewound");
    rd_high("R11 read phase continues");

    // read and control write in the same cycle
    set_mode(1'b1);
    @(negedge clk);
    exp_q.push_back(model_read()); tag_q.push_back("R12 read uses old selection");
    din = ctrl_word(2'd3, 2'd0); wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    model_write(ctrl_word(2'd3, 2'd0));
    rd_word("R12 next read uses new selection");

    repeat (3) @(negedge clk);
    check(dout, {2'b00, status_word}, "R10 dout holds without strobe");

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; bad++;
      $display("FAIL R10: %0d reads produced no result, expected 0", exp_q.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule